// File: doc/BRIEF.md
# Single-Cycle Integer Processor Core

This block is a 32-bit processor that retires one instruction per clock cycle. It supports six operations: register-register add, subtract, bitwise AND and bitwise OR, add-immediate, and branch-if-equal. Each cycle, the instruction at the current program counter is fetched from a 64-word local instruction store. The instruction is decoded, and its operands are read asynchronously from a 32-entry register file. The result is written back on the next rising clock edge, and the program counter moves on at that same edge.

The next-PC logic is a two-way choice. Normally the PC steps to the next word. It takes the branch-target path only when the instruction is a branch and its two source registers hold equal values. The branch target comes from its own adder: the sequential PC plus the sign-extended offset scaled to words.

The instruction store is loaded through a simple write port while the core is held in reset. Two observation outputs expose the state: the current PC, and the contents of one register chosen by a select input.

Top module: `sc_core`

## Requirements
- R1: While `rst_ni` is low, the PC is 0 and every register reads 0.
- R2: When no branch is taken, including a branch whose operands differ, the PC advances by exactly 4 on each rising clock edge.
- R3: A branch (opcode 0x04; compares fields [25:21] and [20:16]) with equal operands loads PC+4 plus the sign-extended 16-bit offset shifted left by 2. Negative offsets move the PC backwards.
- R4: A branch whose two operand fields are both register 0 is always taken, so it serves as an unconditional jump.
- R5: Opcode 0 with function field [5:0] 0x20 writes rs+rt, and with 0x22 writes rs−rt, into register [15:11]. Both wrap modulo 2^32.
- R6: Opcode 0 with function 0x24 writes rs AND rt, and with 0x25 writes rs OR rt, into register [15:11].
- R7: Opcode 0x08 writes rs plus the sign-extended immediate [15:0] into register [20:16]. Negative immediates give the correct signed result.
- R8: Register 0 always reads 0. Writes to it are discarded, so an add with all fields 0 changes no visible state.
- R9: Any other opcode, or opcode 0 with any other function value, writes no register and advances the PC by 4.
- R10: A write on the load port stores the data at word index `imem_waddr_i`. That word is executed when PC[7:2] equals the index.
- R11: `dbg_reg_o` shows the current contents of the register selected by `dbg_sel_i` in the same cycle, and `dbg_pc_o` shows the current PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| imem_we_i | input | 1 | Instruction store write enable |
| imem_waddr_i | input | 6 | Instruction store word index |
| imem_wdata_i | input | 32 | Instruction word to store |
| dbg_sel_i | input | 5 | Register number to observe |
| dbg_pc_o | output | 32 | Current program counter |
| dbg_reg_o | output | 32 | Contents of the selected register |

## Verification
Register write-back and the branch decision fall in the same cycle whenever a branch compares a register that the previous instruction just wrote. The same happens when a write targets the register currently shown on the observation port. Random programs draw all register fields from r0–r7 and keep branch offsets small, so producer-consumer pairs, equal-operand branches and backward loops occur often. A directed loop program adds a counted backward branch. After every cycle, the bench judges the PC and one randomly selected register against its own instruction-level model.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] FN_ADD   = 6'h20;
  localparam logic [5:0] FN_SUB   = 6'h22;
  localparam logic [5:0] FN_AND   = 6'h24;
  localparam logic [5:0] FN_OR    = 6'h25;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR} alu_op_e;

  typedef struct packed {
    logic    rf_we;
    logic    dst_is_rt;
    logic    use_imm;
    logic    is_beq;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_alu.sv
module sc_alu import sc_pkg::*; #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      default: y_o = a_i | b_i;
    endcase
  end
endmodule

// File: rtl/sc_decode.sv
module sc_decode import sc_pkg::*; (
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o = '{rf_we: 1'b0, dst_is_rt: 1'b0, use_imm: 1'b0, is_beq: 1'b0, alu_op: ALU_ADD};
    unique case (opcode_i)
      OP_RTYPE: begin
        unique case (funct_i)
          FN_ADD: begin ctrl_o.rf_we = 1'b1; ctrl_o.alu_op = ALU_ADD; end
          FN_SUB: begin ctrl_o.rf_we = 1'b1; ctrl_o.alu_op = ALU_SUB; end
          FN_AND: begin ctrl_o.rf_we = 1'b1; ctrl_o.alu_op = ALU_AND; end
          FN_OR:  begin ctrl_o.rf_we = 1'b1; ctrl_o.alu_op = ALU_OR;  end
          default: ;
        endcase
      end
      OP_ADDI: begin
        ctrl_o.rf_we     = 1'b1;
        ctrl_o.dst_is_rt = 1'b1;
        ctrl_o.use_imm   = 1'b1;
      end
      OP_BEQ:  ctrl_o.is_beq = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int unsigned W    = 32,
  parameter int unsigned NREG = 32,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] ra_a_i,
  input  logic [AW-1:0] ra_b_i,
  input  logic [AW-1:0] ra_c_i,
  output logic [W-1:0]  rd_a_o,
  output logic [W-1:0]  rd_b_o,
  output logic [W-1:0]  rd_c_o
);
  logic [W-1:0] rf_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) rf_q[i] <= '0;
    end else if (we_i && (waddr_i != '0)) begin
      rf_q[waddr_i] <= wdata_i;
    end
  end

  // register 0 is hardwired to zero on every read port
  assign rd_a_o = (ra_a_i == '0) ? '0 : rf_q[ra_a_i];
  assign rd_b_o = (ra_b_i == '0) ? '0 : rf_q[ra_b_i];
  assign rd_c_o = (ra_c_i == '0) ? '0 : rf_q[ra_c_i];
endmodule

// File: rtl/sc_imem.sv
module sc_imem #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sc_core.sv
module sc_core import sc_pkg::*; #(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned IMEM_DEPTH = 64,
  parameter int unsigned NREG       = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          imem_we_i,
  input  logic [$clog2(IMEM_DEPTH)-1:0] imem_waddr_i,
  input  logic [XLEN-1:0]               imem_wdata_i,
  input  logic [$clog2(NREG)-1:0]       dbg_sel_i,
  output logic [XLEN-1:0]               dbg_pc_o,
  output logic [XLEN-1:0]               dbg_reg_o
);
  localparam int unsigned IAW = $clog2(IMEM_DEPTH);
  localparam int unsigned RAW = $clog2(NREG);

  logic [XLEN-1:0] pc_q, pc_d, pc_seq, pc_br;
  logic [XLEN-1:0] instr, imm_sext, rs_val, rt_val, alu_b, alu_y;
  logic [RAW-1:0]  rs_a, rt_a, rd_a, wr_a;
  logic            take_br, rf_we;
  ctrl_t           ctrl;

  sc_imem #(.W(XLEN), .DEPTH(IMEM_DEPTH)) i_imem (
    .clk_i   (clk_i),
    .we_i    (imem_we_i),
    .waddr_i (imem_waddr_i),
    .wdata_i (imem_wdata_i),
    .raddr_i (pc_q[IAW+1:2]),
    .rdata_o (instr)
  );

  assign rs_a     = RAW'(instr[25:21]);
  assign rt_a     = RAW'(instr[20:16]);
  assign rd_a     = RAW'(instr[15:11]);
  assign imm_sext = {{(XLEN-16){instr[15]}}, instr[15:0]};

  sc_decode i_decode (
    .opcode_i (instr[31:26]),
    .funct_i  (instr[5:0]),
    .ctrl_o   (ctrl)
  );

  assign rf_we = ctrl.rf_we;
  assign wr_a  = ctrl.dst_is_rt ? rt_a : rd_a;

  sc_regfile #(.W(XLEN), .NREG(NREG)) i_regfile (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (rf_we),
    .waddr_i (wr_a),
    .wdata_i (alu_y),
    .ra_a_i  (rs_a),
    .ra_b_i  (rt_a),
    .ra_c_i  (dbg_sel_i),
    .rd_a_o  (rs_val),
    .rd_b_o  (rt_val),
    .rd_c_o  (dbg_reg_o)
  );

  assign alu_b = ctrl.use_imm ? imm_sext : rt_val;

  sc_alu #(.W(XLEN)) i_alu (
    .a_i  (rs_val),
    .b_i  (alu_b),
    .op_i (ctrl.alu_op),
    .y_o  (alu_y)
  );

  // next-PC: sequential step or dedicated branch-offset adder
  assign pc_seq  = pc_q + XLEN'(4);
  assign pc_br   = pc_seq + {imm_sext[XLEN-3:0], 2'b00};
  assign take_br = ctrl.is_beq && (rs_val == rt_val);
  assign pc_d    = take_br ? pc_br : pc_seq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign dbg_pc_o = pc_q;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] instr_i,
  input logic [XLEN-1:0] rs_val_i,
  input logic [XLEN-1:0] rt_val_i,
  input logic            rf_we_i
);
  logic            is_br, br_eq, known_op;
  logic [XLEN-1:0] off_words;

  assign is_br     = (instr_i[31:26] == 6'h04);
  assign br_eq     = (rs_val_i == rt_val_i);
  assign known_op  = (instr_i[31:26] == 6'h00) || (instr_i[31:26] == 6'h08) || is_br;
  assign off_words = {{(XLEN-18){instr_i[15]}}, instr_i[15:0], 2'b00};

  a_r2_seq_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(is_br && br_eq) |=> pc_i == $past(pc_i) + XLEN'(4));

  a_r3_br_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_br && br_eq) |=> pc_i == $past(pc_i) + XLEN'(4) + $past(off_words));

  a_r4_zero_br_eq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_br && instr_i[25:16] == 10'd0) |-> br_eq);

  a_r8_zero_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[25:21] == 5'd0) |-> rs_val_i == '0);

  a_r9_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !known_op |-> !rf_we_i);
endmodule

bind sc_core sc_core_chk #(.XLEN(XLEN)) i_sc_core_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pc_i     (pc_q),
  .instr_i  (instr),
  .rs_val_i (rs_val),
  .rt_val_i (rt_val),
  .rf_we_i  (rf_we)
);

// File: tb/test_sc_core.sv
module test_sc_core;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        imem_we_i = 1'b0;
  logic [5:0]  imem_waddr_i = '0;
  logic [31:0] imem_wdata_i = '0;
  logic [4:0]  dbg_sel_i = '0;
  logic [31:0] dbg_pc_o, dbg_reg_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  sc_core i_sc_core (.*);

  logic [31:0] m_rf [32];
  logic [31:0] m_imem [64];
  logic [31:0] m_pc;
  logic [31:0] prog [64];
  string tag_pc, tag_reg;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] sext(logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic m_write(int r, logic [31:0] v);
    if (r != 0) m_rf[r] = v;
  endtask

  // instruction-level reference step
  task automatic model_step();
    logic [31:0] ins, a, b;
    ins = m_imem[m_pc[7:2]];
    a = m_rf[ins[25:21]];
    b = m_rf[ins[20:16]];
    tag_pc = "R2";
    tag_reg = "R9";
    if (ins[31:26] == 6'h00) begin
      case (ins[5:0])
        6'h20: begin m_write(ins[15:11], a + b); tag_reg = "R5"; end
        6'h22: begin m_write(ins[15:11], a - b); tag_reg = "R5"; end
        6'h24: begin m_write(ins[15:11], a & b); tag_reg = "R6"; end
        6'h25: begin m_write(ins[15:11], a | b); tag_reg = "R6"; end
        default: tag_pc = "R9";
      endcase
      m_pc = m_pc + 4;
    end else if (ins[31:26] == 6'h08) begin
      m_write(ins[20:16], a + sext(ins[15:0]));
      tag_reg = "R7";
      m_pc = m_pc + 4;
    end else if (ins[31:26] == 6'h04) begin
      tag_reg = "R2";
      if (a == b) begin
        tag_pc = (ins[25:16] == 10'd0) ? "R4" : "R3";
        m_pc = m_pc + 4 + {sext(ins[15:0]), 2'b00};
      end else m_pc = m_pc + 4;
    end else begin
      tag_pc = "R9";
      m_pc = m_pc + 4;
    end
  endtask

  task automatic load_and_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    for (int i = 0; i < 64; i++) begin
      imem_we_i = 1'b1;
      imem_waddr_i = 6'(i);
      imem_wdata_i = prog[i];
      m_imem[i] = prog[i];
      @(negedge clk_i);
    end
    imem_we_i = 1'b0;
    for (int i = 0; i < 32; i++) m_rf[i] = '0;
    m_pc = '0;
    check("R1 pc", dbg_pc_o, 32'd0);
    for (int i = 0; i < 4; i++) begin
      dbg_sel_i = 5'($urandom_range(0, 31));
      #1 check("R1 reg", dbg_reg_o, 32'd0);
    end
    rst_ni = 1'b1;
  endtask

  task automatic run(int cycles);
    for (int c = 0; c < cycles; c++) begin
      model_step();
      @(negedge clk_i);
      check({tag_pc, " pc"}, dbg_pc_o, m_pc);
      dbg_sel_i = 5'($urandom_range(0, 9));
      #1;
      if (dbg_sel_i == 0) check("R8 r0", dbg_reg_o, 32'd0);
      else check({tag_reg, "/R11 reg"}, dbg_reg_o, m_rf[dbg_sel_i]);
    end
  endtask

  task automatic check_reg(int r, logic [31:0] exp, string req);
    dbg_sel_i = 5'(r);
    #1 check(req, dbg_reg_o, exp);
  endtask

  function automatic logic [31:0] rand_instr();
    int k = $urandom_range(0, 7);
    int rs = $urandom_range(0, 7);
    int rt = $urandom_range(0, 7);
    int rd = $urandom_range(0, 7);
    logic [5:0] bad_op [3] = '{6'h3f, 6'h23, 6'h02};
    case (k)
      0: return enc_r(rs, rt, rd, 6'h20);
      1: return enc_r(rs, rt, rd, 6'h22);
      2: return enc_r(rs, rt, rd, 6'h24);
      3: return enc_r(rs, rt, rd, 6'h25);
      4: return enc_i(6'h08, rs, rt, 16'($urandom));
      5: return enc_i(6'h04, rs, rt, 16'($signed($urandom_range(0, 15)) - 8));
      6: return enc_i(bad_op[$urandom_range(0, 2)], rs, rt, 16'($urandom));
      default: return enc_r(rs, rt, rd, 6'h21);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    // directed program: arithmetic, r0 write, counted backward loop, bad codes
    for (int i = 0; i < 64; i++) prog[i] = 32'h0;
    prog[0]  = enc_i(6'h08, 0, 4, 16'd4);
    prog[1]  = enc_i(6'h08, 4, 2, 16'hfffd);
    prog[2]  = enc_r(2, 4, 3, 6'h20);
    prog[3]  = enc_r(2, 4, 5, 6'h22);
    prog[4]  = enc_r(5, 3, 6, 6'h24);
    prog[5]  = enc_r(5, 3, 7, 6'h25);
    prog[6]  = enc_r(4, 4, 0, 6'h20);
    prog[7]  = enc_i(6'h04, 2, 4, 16'd2);
    prog[8]  = enc_i(6'h08, 2, 2, 16'd1);
    prog[9]  = enc_i(6'h04, 0, 0, 16'hfffd);
    prog[10] = enc_i(6'h3f, 0, 8, 16'h1234);
    prog[11] = enc_r(4, 4, 8, 6'h00);
    prog[12] = enc_r(0, 0, 0, 6'h20);
    load_and_reset();
    run(24);
    check_reg(4, 32'd4, "R7 r4");
    check_reg(2, 32'd4, "R3 loop count r2");
    check_reg(3, 32'd5, "R5 add r3");
    check_reg(5, 32'hfffffffd, "R5 sub r5");
    check_reg(6, 32'd5, "R6 and r6");
    check_reg(7, 32'hfffffffd, "R6 or r7");
    check_reg(8, 32'd0, "R9 r8 untouched");
    check_reg(0, 32'd0, "R8 r0");

    // R10: a single loaded word at index 5 among no-ops
    for (int i = 0; i < 64; i++) prog[i] = 32'h0;
    prog[5] = enc_i(6'h08, 0, 9, 16'h0055);
    load_and_reset();
    run(5);
    check_reg(9, 32'd0, "R10 before fetch");
    run(1);
    check_reg(9, 32'h55, "R10 after fetch");

    // constrained random programs
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 64; i++) prog[i] = rand_instr();
      load_and_reset();
      run(400);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule